// File: doc/BRIEF.md
# Accuracy-Configurable Timing-Error Control Unit

This unit sits beside a single-precision floating-point pipeline whose stages flag a possible timing error on each bit of the result word. When a result is presented, the unit merges the flags of all stages and masks them according to the active accuracy mode. It then either accepts the result or asks for the operation to be replayed. The clock frequency never changes; a replay is the only correction.

In accurate mode every flag counts. In approximate mode the flags on the lowest N fraction bits are dropped, and the sign and exponent bits are always checked. Software sets the mode and N through a small register bus and may change them between any two results. Accurate and approximate code can therefore be interleaved result by result. Three saturating counters record the error cycles, the elapsed cycles and the accepted operations. Software reads them to compute a vulnerability ratio for scheduling.

Top module: `fp_timing_err_ctrl`

## Requirements
- R1: In accurate mode (control bit 0 = 0), a result with any flag set in any stage drives replay_o high for exactly one cycle, in the cycle after res_valid_i. done_o stays low for that result.
- R2: A result with no unmasked flag drives done_o high for one cycle, in the cycle after res_valid_i, with replay_o low. With no result presented, both outputs stay low.
- R3: In approximate mode (control bit 0 = 1), flags on fraction bits 0 to N-1 (bits 22..0 of the word) are ignored, and the result is accepted with done_o.
- R4: In approximate mode, a flag on any fraction bit at or above N still causes a replay. With N = 0 this includes bit 0.
- R5: A flag on the sign bit (bit 31) or an exponent bit (bits 30..23) causes a replay in either mode.
- R6: The control register is at address 0. Bit 0 selects approximate mode, and bits 12..8 hold N. A written N above 23 is stored as 23. Reads return the stored value.
- R7: Address 1 reads the count of results with an unmasked error. Address 2 reads the count of clock cycles since reset or clear. Address 3 reads the count of accepted operations, so a replayed attempt adds no operation.
- R8: Each counter stops at its all-ones value instead of wrapping.
- R9: Any write to address 4 clears all three counters at that clock edge. Writes to addresses 1 to 3 leave the counters unchanged.
- R10: A control write takes effect for the first result presented after the write edge. A result presented in the same cycle as the write uses the previous setting, even when results arrive back to back.
- R11: After reset, replay_o and done_o are low, the control register and the error and operation counters read 0, and the cycle counter starts from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | A pipeline result and its flags are present this cycle |
| err_flags_i | input | NUM_STAGES*32 | Per-bit timing-error flags, stage s at bits [s*32 +: 32] |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |
| replay_o | output | 1 | One-cycle request to replay the last result |
| done_o | output | 1 | One-cycle acceptance of the last result |

## Verification
The bench checks the edge of the mask: bits N-1 and N in approximate mode, N = 0, and N written as 31 and clamped to 23, so bit 22 is ignored and bit 23 is not. A design off by one at that edge would accept a real error or replay a harmless one. The bench places sign and exponent flags in a stage other than the first, so a design that drops the high-bit guard, or checks only one stage, accepts results it should replay. Back-to-back results around a mode write expose a design that applies the new setting one result too early. Reads after writes to the read-only addresses, after a clear, and from a narrow-counter instance catch counters that take the write, keep old counts, or wrap.

// File: rtl/tec_pkg.sv
package tec_pkg;
  localparam int WORD_W   = 32;
  localparam int FRAC_W   = 23;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int N_W      = $clog2(FRAC_W + 1);
  localparam int N_LSB    = 8;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_ERRC  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TOTC  = 3'd2;
  localparam logic [ADDR_W-1:0] A_OPSC  = 3'd3;
  localparam logic [ADDR_W-1:0] A_CLEAR = 3'd4;
endpackage

// File: rtl/tec_err_mask.sv
module tec_err_mask
  import tec_pkg::*;
(
  input  logic              approx_i,
  input  logic [N_W-1:0]    n_i,
  output logic [WORD_W-1:0] mask_o
);
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (b >= FRAC_W) begin : g_guard
      assign mask_o[b] = 1'b1;  // sign and exponent always checked
    end else begin : g_frac
      assign mask_o[b] = !approx_i || (n_i <= N_W'(b));
    end
  end
endmodule

// File: rtl/tec_sat_cnt.sv
module tec_sat_cnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end

  a_r8_sat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX);
  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_o == '0);
endmodule

// File: rtl/tec_regs.sv
module tec_regs
  import tec_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [COUNT_W-1:0] err_cnt_i,
  input  logic [COUNT_W-1:0] tot_cnt_i,
  input  logic [COUNT_W-1:0] ops_cnt_i,
  output logic               approx_o,
  output logic [N_W-1:0]     n_o,
  output logic               clr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam logic [N_W-1:0] N_MAX = N_W'(FRAC_W);
  logic [N_W-1:0] n_wr;

  assign n_wr  = wdata_i[N_LSB +: N_W];
  assign clr_o = we_i && (addr_i == A_CLEAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      approx_o <= 1'b0;
      n_o      <= '0;
    end else if (we_i && addr_i == A_CTRL) begin
      approx_o <= wdata_i[0];
      n_o      <= (n_wr > N_MAX) ? N_MAX : n_wr;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[0]             = approx_o;
        rdata_o[N_LSB +: N_W]  = n_o;
      end
      A_ERRC:  rdata_o[COUNT_W-1:0] = err_cnt_i;
      A_TOTC:  rdata_o[COUNT_W-1:0] = tot_cnt_i;
      A_OPSC:  rdata_o[COUNT_W-1:0] = ops_cnt_i;
      default: rdata_o = '0;
    endcase
  end

  a_r6_n_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_o <= N_MAX);
endmodule

// File: rtl/fp_timing_err_ctrl.sv
module fp_timing_err_ctrl
  import tec_pkg::*;
#(
  parameter int NUM_STAGES = 2,
  parameter int COUNT_W    = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         res_valid_i,
  input  logic [NUM_STAGES*WORD_W-1:0] err_flags_i,
  input  logic                         reg_we_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [DATA_W-1:0]            reg_wdata_i,
  output logic [DATA_W-1:0]            reg_rdata_o,
  output logic                         replay_o,
  output logic                         done_o
);
  logic              approx, clr;
  logic [N_W-1:0]    n_bits;
  logic [WORD_W-1:0] merged, mask;
  logic              hit;
  logic [COUNT_W-1:0] err_cnt, tot_cnt, ops_cnt;

  always_comb begin
    merged = '0;
    for (int s = 0; s < NUM_STAGES; s++) merged |= err_flags_i[s*WORD_W +: WORD_W];
  end

  tec_err_mask u_mask (.approx_i(approx), .n_i(n_bits), .mask_o(mask));

  assign hit = |(merged & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      replay_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      replay_o <= res_valid_i && hit;
      done_o   <= res_valid_i && !hit;
    end
  end

  tec_sat_cnt #(.W(COUNT_W)) u_err_cnt (.clk_i, .rst_ni, .clr_i(clr),
    .inc_i(res_valid_i && hit), .cnt_o(err_cnt));
  tec_sat_cnt #(.W(COUNT_W)) u_tot_cnt (.clk_i, .rst_ni, .clr_i(clr),
    .inc_i(1'b1), .cnt_o(tot_cnt));
  tec_sat_cnt #(.W(COUNT_W)) u_ops_cnt (.clk_i, .rst_ni, .clr_i(clr),
    .inc_i(res_valid_i && !hit), .cnt_o(ops_cnt));

  tec_regs #(.COUNT_W(COUNT_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .err_cnt_i(err_cnt), .tot_cnt_i(tot_cnt), .ops_cnt_i(ops_cnt),
    .approx_o(approx), .n_o(n_bits), .clr_o(clr), .rdata_o(reg_rdata_o));

  // assertion-only view of the guarded high bits
  logic hi_flag;
  always_comb begin
    hi_flag = 1'b0;
    for (int s = 0; s < NUM_STAGES; s++)
      hi_flag |= |err_flags_i[s*WORD_W + FRAC_W +: WORD_W - FRAC_W];
  end

  a_r1_accurate_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && !approx && |err_flags_i) |=> (replay_o && !done_o));
  a_r5_guard_replay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && hi_flag) |=> replay_o);
  a_r2_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_o |-> !done_o);
  a_r2_needs_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (replay_o || done_o) |-> $past(res_valid_i));
endmodule

// File: tb/fp_timing_err_ctrl_test.sv
module fp_timing_err_ctrl_test;
  import tec_pkg::*;
  localparam int NS = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [NS*WORD_W-1:0] flags = '0;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata, s_rdata;
  logic replay, done, s_replay, s_done;

  fp_timing_err_ctrl #(.NUM_STAGES(NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(res_valid), .err_flags_i(flags),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .replay_o(replay), .done_o(done));

  fp_timing_err_ctrl #(.NUM_STAGES(NS), .COUNT_W(6)) sat_uut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(1'b0), .err_flags_i('0),
    .reg_we_i(1'b0), .reg_addr_i(A_TOTC), .reg_wdata_i('0),
    .reg_rdata_o(s_rdata), .replay_o(s_replay), .done_o(s_done));

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [1:0] exp_q[$];
  string      tag_q[$];
  bit m_approx = 0;
  int m_n = 0, e_err = 0, e_ops = 0, m_tot = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit model_hit(logic [31:0] c);
    bit h = |c[31:23];
    for (int i = 0; i < 23; i++) if (!m_approx || i >= m_n) h |= c[i];
    return h;
  endfunction

  // cycle-count model
  always @(posedge clk or negedge rst_n)
    if (!rst_n) m_tot <= 0;
    else if (reg_we && reg_addr == A_CLEAR) m_tot <= 0;
    else m_tot <= m_tot + 1;

  task automatic step(bit v, logic [31:0] f0, logic [31:0] f1, bit we,
                      logic [2:0] a, logic [31:0] wd, string tag);
    bit h;
    @(negedge clk);
    res_valid = v; flags = {f1, f0};
    reg_we = we; reg_addr = a; reg_wdata = wd;
    if (v) begin
      h = model_hit(f0 | f1);
      exp_q.push_back({h, !h});
      tag_q.push_back(tag);
      if (h) e_err++; else e_ops++;
    end
    if (we && a == A_CTRL) begin
      m_approx = wd[0];
      m_n = (wd[12:8] > 23) ? 23 : int'(wd[12:8]);
    end
    if (we && a == A_CLEAR) begin e_err = 0; e_ops = 0; end
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0, "");
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    res_valid = 0; reg_we = 0; reg_addr = a;
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic rd_tot(string tag);
    @(negedge clk);
    res_valid = 0; reg_we = 0; reg_addr = A_TOTC;
    #1 chk(tag, reg_rdata, m_tot);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin : mon
    logic v;
    logic [1:0] e;
    string t;
    v = res_valid;
    #2;
    if (rst_n) begin
      if (v) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 scoreboard empty actual=%b expected=item", {replay, done});
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {30'd0, replay, done}, {30'd0, e});
        end
      end else if (replay || done) begin
        checks++; fails++;
        $display("FAIL R2 output without result actual=%b expected=00", {replay, done});
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 outputs in reset", {30'd0, replay, done}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd(A_CTRL, 32'd0, "R11 ctrl after reset");
    rd(A_ERRC, 32'd0, "R11 err count after reset");
    rd(A_OPSC, 32'd0, "R11 ops count after reset");
    rd_tot("R11 cycle count after reset");

    step(0, '0, '0, 1, A_CLEAR, 32'd1, "");
    // accurate mode
    step(1, 32'h0, 32'h0, 0, '0, '0, "R2 clean result");
    step(1, 32'h0, 32'h1, 0, '0, '0, "R1 bit0 stage1");
    step(1, 32'h0040_0000, 32'h0, 0, '0, '0, "R1 bit22 stage0");
    // approximate, N=8
    step(0, '0, '0, 1, A_CTRL, 32'h0000_0801, "");
    rd(A_CTRL, 32'h0000_0801, "R6 ctrl readback");
    step(1, 32'h8, 32'h0, 0, '0, '0, "R3 bit3 masked");
    step(1, 32'h0, 32'h80, 0, '0, '0, "R3 bit7 masked");
    step(1, 32'h100, 32'h0, 0, '0, '0, "R4 bit8 checked");
    step(1, 32'h4, 32'h200, 0, '0, '0, "R4 bit9 stage1");
    step(1, 32'h8000_0000, 32'h0, 0, '0, '0, "R5 sign bit");
    step(1, 32'h0, 32'h0200_0000, 0, '0, '0, "R5 exponent stage1");
    // N=0 approximate
    step(0, '0, '0, 1, A_CTRL, 32'h0000_0001, "");
    step(1, 32'h1, 32'h0, 0, '0, '0, "R4 N0 bit0 checked");
    // clamp
    step(0, '0, '0, 1, A_CTRL, 32'h0000_1F01, "");
    rd(A_CTRL, 32'h0000_1701, "R6 N clamped to 23");
    step(1, 32'h0040_0000, 32'h0, 0, '0, '0, "R3 bit22 masked N23");
    step(1, 32'h0, 32'h0080_0000, 0, '0, '0, "R5 bit23 guarded");
    // back-to-back interleave
    step(1, 32'h20, 32'h0, 1, A_CTRL, 32'h0, "R10 old approx mode");
    step(1, 32'h20, 32'h0, 0, '0, '0, "R10 new accurate mode");
    step(1, 32'h20, 32'h0, 1, A_CTRL, 32'h0000_0801, "R10 old accurate mode");
    step(1, 32'h20, 32'h0, 0, '0, '0, "R10 new approx mode");
    idle();
    rd(A_ERRC, e_err, "R7 error cycles");
    rd(A_OPSC, e_ops, "R7 accepted ops");
    rd_tot("R7 total cycles");
    // read-only addresses
    step(0, '0, '0, 1, A_ERRC, 32'h0, "");
    step(0, '0, '0, 1, A_OPSC, 32'h0, "");
    step(0, '0, '0, 1, A_TOTC, 32'h0, "");
    rd(A_ERRC, e_err, "R9 err write ignored");
    rd(A_OPSC, e_ops, "R9 ops write ignored");
    rd_tot("R9 tot write ignored");
    // clear
    step(0, '0, '0, 1, A_CLEAR, 32'h0, "");
    rd(A_ERRC, 32'd0, "R9 err cleared");
    rd(A_OPSC, 32'd0, "R9 ops cleared");
    rd_tot("R9 tot restarts after clear");
    // saturation on the narrow instance
    repeat (80) @(negedge clk);
    #1 chk("R8 counter saturates", s_rdata, 32'd63);
    idle(); idle();
    chk("R2 scoreboard drained", exp_q.size(), 32'd0);
    summary();
  end
endmodule